// File: doc/BRIEF.md
# Timeout-Driven Power State Controller

This block decides when a processing unit may drop out of full operation. It watches a level busy indicator and a wake/interrupt line and walks the unit through three resting levels. In run the unit works normally. In idle the core clock is gated but interrupts are still watched. In sleep all on-chip activity is shut down. Each move between levels passes through a named transition state whose length is a parameterised number of clock cycles. The latencies are asymmetric: the short idle entry and idle exit on one side, and the medium sleep entry and very long wake-up on the other. No transition is ever cut short.

Going from idle into deep sleep needs two conditions. The unit must have stayed idle for a programmable number of cycles. A history predictor must also agree. The predictor keeps a sliding window of recent busy/idle samples and forecasts a long idle period only when few of those samples were busy. Every shutdown is counted. A shutdown that is woken again before a programmable break-even time is also counted as a wrong shutdown. Both counts are visible at the ports.

States: `PS_RUN`, `PS_TO_IDLE`, `PS_IDLE`, `PS_IDLE_EXIT`, `PS_TO_SLEEP`, `PS_SLEEP`, `PS_WAKE`. Transitions:
- run→to_idle on sustained inactivity.
- to_idle→idle when its timer ends.
- idle→idle_exit on activity or a pending wake.
- idle_exit→run when its timer ends.
- idle→to_sleep on the shutdown condition.
- to_sleep→sleep when its timer ends.
- sleep→wake on a wake request.
- wake→run when its timer ends.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the block is in run: `state_o` = 2'b00, `clk_en_o` = 1, `pdn_req_o` = 0, and both event counts are zero.
- R2: `state_o` encodes run as 2'b00, idle as 2'b01 and sleep as 2'b10, and shows 2'b11 in every transition state. `clk_en_o` is low only in idle and sleep. `pdn_req_o` is high only in the sleep-entry transition and in sleep.
- R3: In run, an activity-free cycle (busy_i and wake_i both low) increments an idle count, and any activity clears it. On the first edge at which the count already equals or exceeds `idle_thresh_i` with no activity, the block enters the idle-entry transition.
- R4: The idle-entry transition lasts exactly LAT_IDLE_IN cycles. The idle-exit transition lasts exactly LAT_IDLE_OUT cycles.
- R5: In idle, busy_i or wake_i high (or a latched wake) starts the idle-exit transition on the next edge. The idle-exit transition ends in run.
- R6: The idle count restarts at zero on entry to idle. Sleep entry starts only when the count has reached `shut_thresh_i` and the predictor forecasts a long idle. With a quiet history, idle is therefore shown for `shut_thresh_i`+1 cycles.
- R7: The predictor records one window bit per SAMP cycles. The bit is 1 if busy_i was high in any cycle of that period. The window holds WIN bits and is all ones after reset. A long idle is forecast only when at most BUSY_MAX window bits are 1, so recent busy history delays sleep beyond `shut_thresh_i`.
- R8: The sleep-entry transition lasts exactly LAT_SLP_IN cycles and ends in sleep. The wake transition lasts exactly LAT_WAKE cycles and ends in run.
- R9: In sleep, busy_i has no effect. Only wake_i (or a latched wake) leaves sleep.
- R10: A wake_i pulse during a transition is latched and does not shorten it. After idle entry, idle is shown for one cycle and then the idle-exit transition follows. After sleep entry, sleep is shown for one cycle and then the wake transition follows.
- R11: `shut_cnt_o` increments on every entry into the sleep-entry transition. `wrong_cnt_o` increments when sleep is left fewer than `breakeven_i` cycles after that entry began.
- R12: Both counts saturate at their all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Workload busy level |
| wake_i | input | 1 | Wake / interrupt request |
| idle_thresh_i | input | CW | Idle cycles in run before idle entry |
| shut_thresh_i | input | CW | Idle cycles in idle before sleep entry |
| breakeven_i | input | CW | Minimum cycles of a worthwhile shutdown |
| state_o | output | 2 | Power state code |
| clk_en_o | output | 1 | Core clock enable |
| pdn_req_o | output | 1 | Power-down request |
| shut_cnt_o | output | CNT_W | Saturating shutdown count |
| wrong_cnt_o | output | CNT_W | Saturating wrong-shutdown count |

## Verification
The assertions check the following on every cycle:
- the step-by-step countdown of the transition timer;
- that sleep is reachable only through its entry transition, and only with a positive forecast;
- that sleep is held while no wake is present;
- that a running sleep entry is never abandoned;
- the clock-gate/state relation;
- the monotonic, saturating behaviour of the counters;
- the shifting of the history window.

Only the bench scenarios can show the exact length of each transition, the way a busy history stretches the stay in idle, the one-cycle visit caused by a latched wake, and the split between right and wrong shutdowns against the break-even time.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [2:0] {
        PS_RUN,
        PS_TO_IDLE,
        PS_IDLE,
        PS_IDLE_EXIT,
        PS_TO_SLEEP,
        PS_SLEEP,
        PS_WAKE
    } pwr_st_e;

    localparam logic [1:0] CODE_RUN   = 2'b00;
    localparam logic [1:0] CODE_IDLE  = 2'b01;
    localparam logic [1:0] CODE_SLEEP = 2'b10;
    localparam logic [1:0] CODE_TRANS = 2'b11;

    function automatic logic is_transition(input pwr_st_e s);
        return (s == PS_TO_IDLE) || (s == PS_IDLE_EXIT) ||
               (s == PS_TO_SLEEP) || (s == PS_WAKE);
    endfunction

endpackage

// File: rtl/psc_timer.sv
module psc_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    // R4 / R8: once loaded, the count falls by exactly one per cycle
    assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/psc_predictor.sv
module psc_predictor #(
    parameter int WIN      = 8,
    parameter int SAMP     = 4,
    parameter int BUSY_MAX = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    output logic long_o
);
    localparam int SW = (SAMP > 1) ? $clog2(SAMP) : 1;
    localparam int OW = $clog2(WIN + 1);

    logic [SW-1:0]  scnt;
    logic           acc;
    logic           tick;
    logic [WIN-1:0] win;
    logic [OW-1:0]  ones;

    assign tick = (scnt == SW'(SAMP - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scnt <= '0;
            acc  <= 1'b0;
            win  <= '1;
        end else if (tick) begin
            scnt <= '0;
            acc  <= 1'b0;
            win  <= {win[WIN-2:0], acc | busy_i};
        end else begin
            scnt <= scnt + 1'b1;
            acc  <= acc | busy_i;
        end
    end

    always_comb begin
        ones = '0;
        for (int i = 0; i < WIN; i++) begin
            ones = ones + OW'(win[i]);
        end
    end

    assign long_o = (int'(ones) <= BUSY_MAX);

    // R7: each sample period pushes the window by one slot
    assert_window_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (win[WIN-1:1] == $past(win[WIN-2:0])));

    // R7: between sample points the window is frozen
    assert_window_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(win));

endmodule

// File: rtl/psc_sat_counter.sv
module psc_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (inc && (cnt_o != '1)) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    // R12: the all-ones value is sticky
    assert_cnt_hold_max_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '1) |=> (cnt_o == '1));

    // R11: an event count never falls
    assert_cnt_monotonic_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_o >= $past(cnt_o)));

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import pwr_pkg::*;
#(
    parameter int CW           = 16,
    parameter int CNT_W        = 8,
    parameter int LAT_IDLE_IN  = 10,
    parameter int LAT_IDLE_OUT = 10,
    parameter int LAT_SLP_IN   = 90,
    parameter int LAT_WAKE     = 160,
    parameter int WIN          = 8,
    parameter int SAMP         = 4,
    parameter int BUSY_MAX     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  logic             wake_i,
    input  logic [CW-1:0]    idle_thresh_i,
    input  logic [CW-1:0]    shut_thresh_i,
    input  logic [CW-1:0]    breakeven_i,
    output logic [1:0]       state_o,
    output logic             clk_en_o,
    output logic             pdn_req_o,
    output logic [CNT_W-1:0] shut_cnt_o,
    output logic [CNT_W-1:0] wrong_cnt_o
);
    localparam int LAT_A   = (LAT_IDLE_IN > LAT_IDLE_OUT) ? LAT_IDLE_IN : LAT_IDLE_OUT;
    localparam int LAT_B   = (LAT_SLP_IN > LAT_WAKE) ? LAT_SLP_IN : LAT_WAKE;
    localparam int LAT_MAX = (LAT_A > LAT_B) ? LAT_A : LAT_B;
    localparam int TW      = $clog2(LAT_MAX + 1);

    pwr_st_e       st, nxt;
    logic          activity;
    logic          pend;
    logic          pred_long;
    logic          tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;
    logic [CW-1:0] idle_cnt;
    logic [CW-1:0] be_cnt;
    logic          shut_inc, wrong_inc;

    assign activity = busy_i | wake_i;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= PS_RUN;
        else        st <= nxt;
    end

    // next-state decision
    always_comb begin
        nxt = st;
        unique case (st)
            PS_RUN:       if (!activity && idle_cnt >= idle_thresh_i) nxt = PS_TO_IDLE;
            PS_TO_IDLE:   if (tmr_done) nxt = PS_IDLE;
            PS_IDLE: begin
                if (activity || pend)                              nxt = PS_IDLE_EXIT;
                else if (idle_cnt >= shut_thresh_i && pred_long)   nxt = PS_TO_SLEEP;
            end
            PS_IDLE_EXIT: if (tmr_done) nxt = PS_RUN;
            PS_TO_SLEEP:  if (tmr_done) nxt = PS_SLEEP;
            PS_SLEEP:     if (wake_i || pend) nxt = PS_WAKE;
            PS_WAKE:      if (tmr_done) nxt = PS_RUN;
            default:      nxt = PS_RUN;
        endcase
    end

    // transition timer load
    always_comb begin
        tmr_load = (nxt != st) && is_transition(nxt);
        unique case (nxt)
            PS_TO_IDLE:   tmr_val = TW'(LAT_IDLE_IN - 1);
            PS_IDLE_EXIT: tmr_val = TW'(LAT_IDLE_OUT - 1);
            PS_TO_SLEEP:  tmr_val = TW'(LAT_SLP_IN - 1);
            PS_WAKE:      tmr_val = TW'(LAT_WAKE - 1);
            default:      tmr_val = '0;
        endcase
    end

    psc_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    psc_predictor #(.WIN(WIN), .SAMP(SAMP), .BUSY_MAX(BUSY_MAX)) u_pred (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_i (busy_i),
        .long_o (pred_long)
    );

    // continuous idle count, only meaningful in run and idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (activity || !(st == PS_RUN || st == PS_IDLE)) begin
            idle_cnt <= '0;
        end else if (idle_cnt != '1) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // wake latch for requests that arrive mid-transition
    always_ff @(posedge clk) begin
        if (!rst_n)             pend <= 1'b0;
        else if (st == PS_RUN)  pend <= 1'b0;
        else if (wake_i)        pend <= 1'b1;
    end

    // elapsed time since shutdown began
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            be_cnt <= '0;
        end else if (st == PS_IDLE && nxt == PS_TO_SLEEP) begin
            be_cnt <= '0;
        end else if ((st == PS_TO_SLEEP || st == PS_SLEEP) && be_cnt != '1) begin
            be_cnt <= be_cnt + 1'b1;
        end
    end

    assign shut_inc  = (st == PS_IDLE) && (nxt == PS_TO_SLEEP);
    assign wrong_inc = (st == PS_SLEEP) && (nxt == PS_WAKE) && (be_cnt < breakeven_i);

    psc_sat_counter #(.W(CNT_W)) u_shut_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (shut_inc),
        .cnt_o (shut_cnt_o)
    );

    psc_sat_counter #(.W(CNT_W)) u_wrong_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (wrong_inc),
        .cnt_o (wrong_cnt_o)
    );

    // outputs
    always_comb begin
        unique case (st)
            PS_RUN:      begin state_o = CODE_RUN;   clk_en_o = 1'b1; pdn_req_o = 1'b0; end
            PS_IDLE:     begin state_o = CODE_IDLE;  clk_en_o = 1'b0; pdn_req_o = 1'b0; end
            PS_SLEEP:    begin state_o = CODE_SLEEP; clk_en_o = 1'b0; pdn_req_o = 1'b1; end
            PS_TO_SLEEP: begin state_o = CODE_TRANS; clk_en_o = 1'b1; pdn_req_o = 1'b1; end
            default:     begin state_o = CODE_TRANS; clk_en_o = 1'b1; pdn_req_o = 1'b0; end
        endcase
    end

    // R2: a gated clock only ever accompanies a resting state
    assert_clk_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en_o |-> (state_o == CODE_IDLE || state_o == CODE_SLEEP));

    // R5: activity in idle starts the exit path
    assert_idle_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_IDLE && busy_i) |=> (st == PS_IDLE_EXIT));

    // R6: sleep entry only follows a positive forecast
    assert_shut_predicted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_TO_SLEEP && $past(st) == PS_IDLE) |-> $past(pred_long));

    // R8: sleep is reached only through its entry transition
    assert_sleep_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_SLEEP && $past(st) != PS_SLEEP) |-> ($past(st) == PS_TO_SLEEP));

    // R9: without a wake, sleep is held
    assert_sleep_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_SLEEP && !wake_i && !pend) |=> (st == PS_SLEEP));

    // R10: sleep entry is never abandoned before its timer ends
    assert_no_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_TO_SLEEP && !tmr_done) |=> (st == PS_TO_SLEEP));

endmodule

// File: tb/sim_pwr_state_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_state_ctrl;
    localparam int CW    = 8;
    localparam int CNT_W = 2;
    localparam int L_II  = 6;
    localparam int L_IO  = 5;
    localparam int L_SI  = 12;
    localparam int L_WK  = 20;
    localparam int THR_I = 4;
    localparam int THR_S = 8;
    localparam int BE    = 30;

    // {busy, wake, hold[7:0], state[1:0], clk_en, pdn, pad[1:0]}
    localparam logic [15:0] VEC [6] = '{
        {1'b1, 1'b0, 8'd40, 2'b00, 1'b1, 1'b0, 2'b00},  // R1/R2 run under load
        {1'b0, 1'b0, 8'd2,  2'b00, 1'b1, 1'b0, 2'b00},  // R3 below threshold
        {1'b0, 1'b0, 8'd5,  2'b11, 1'b1, 1'b0, 2'b00},  // R3/R4 idle entry
        {1'b0, 1'b0, 8'd6,  2'b01, 1'b0, 1'b0, 2'b00},  // R2/R7 idle, history blocks sleep
        {1'b1, 1'b0, 8'd1,  2'b11, 1'b1, 1'b0, 2'b00},  // R5 exit on busy
        {1'b1, 1'b0, 8'd10, 2'b00, 1'b1, 1'b0, 2'b00}   // R5 back in run
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busy = 1'b0;
    logic wake = 1'b0;
    logic [1:0] state;
    logic clk_en, pdn;
    logic [CNT_W-1:0] sh_cnt, wr_cnt;
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwr_state_ctrl #(
        .CW(CW), .CNT_W(CNT_W), .LAT_IDLE_IN(L_II), .LAT_IDLE_OUT(L_IO),
        .LAT_SLP_IN(L_SI), .LAT_WAKE(L_WK), .WIN(8), .SAMP(4), .BUSY_MAX(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .wake_i(wake),
        .idle_thresh_i(CW'(THR_I)), .shut_thresh_i(CW'(THR_S)), .breakeven_i(CW'(BE)),
        .state_o(state), .clk_en_o(clk_en), .pdn_req_o(pdn),
        .shut_cnt_o(sh_cnt), .wrong_cnt_o(wr_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_gt(input string req, input int act, input int lim);
        tests++;
        if (act <= lim) begin
            fails++;
            $display("FAIL %s: actual %0d expected more than %0d", req, act, lim);
        end
    endtask

    // counts negedges (including the current one) with state equal to code
    task automatic dwell(input logic [1:0] code, output int n);
        n = 0;
        while (state == code && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_wake();
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
    endtask

    task automatic wait_pdn();
        for (int k = 0; k < 2000 && !pdn; k++) @(negedge clk);
    endtask

    task automatic wait_run();
        for (int k = 0; k < 2000 && state != 2'b00; k++) @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 state", int'(state), 0);
        chk("R1 clk_en", int'(clk_en), 1);
        chk("R1 pdn", int'(pdn), 0);
        chk("R1 shut count", int'(sh_cnt), 0);
        chk("R1 wrong count", int'(wr_cnt), 0);
        rst_n = 1'b1;

        // vector table
        for (int v = 0; v < 6; v++) begin
            busy = VEC[v][15];
            wake = VEC[v][14];
            repeat (int'(VEC[v][13:6])) @(negedge clk);
            chk($sformatf("R2 vec%0d state", v), int'(state), int'(VEC[v][5:4]));
            chk($sformatf("R2 vec%0d clk_en", v), int'(clk_en), int'(VEC[v][3]));
            chk($sformatf("R2 vec%0d pdn", v), int'(pdn), int'(VEC[v][2]));
        end

        // busy history present, then quiet: full path to sleep
        busy = 1'b0;
        @(negedge clk);
        dwell(2'b00, n); chk("R3 run cycles after busy drop", n, THR_I);
        dwell(2'b11, n); chk("R4 idle entry length", n, L_II);
        chk("R2 idle clk_en", int'(clk_en), 0);
        dwell(2'b01, n); chk_gt("R7 busy history stretches idle", n, THR_S + 1);
        chk("R2 sleep entry pdn", int'(pdn), 1);
        chk("R2 sleep entry clk_en", int'(clk_en), 1);
        dwell(2'b11, n); chk("R8 sleep entry length", n, L_SI);
        chk("R2 sleep pdn", int'(pdn), 1);
        chk("R2 sleep clk_en", int'(clk_en), 0);
        repeat (40) @(negedge clk);
        chk("R9 sleep held", int'(state), 2);
        pulse_wake();
        dwell(2'b11, n); chk("R8 wake length", n, L_WK);
        chk("R11 shut count 1", int'(sh_cnt), 1);
        chk("R11 late wake not wrong", int'(wr_cnt), 0);

        // quiet history: exact idle stay
        dwell(2'b00, n); chk("R3 run cycles after wake", n, THR_I + 1);
        dwell(2'b11, n); chk("R4 idle entry length again", n, L_II);
        dwell(2'b01, n); chk("R6 idle stay with quiet history", n, THR_S + 1);
        dwell(2'b11, n); chk("R8 sleep entry length again", n, L_SI);
        busy = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (state != 2'b10) chk("R9 busy ignored in sleep", int'(state), 2);
        end
        chk("R9 still asleep under busy", int'(state), 2);
        busy = 1'b0;
        pulse_wake();
        dwell(2'b11, n); chk("R8 wake length again", n, L_WK);
        chk("R11 shut count 2", int'(sh_cnt), 2);
        chk("R11 wrong count still 0", int'(wr_cnt), 0);

        // wake latched during idle entry
        for (int k = 0; k < 100 && state == 2'b00; k++) @(negedge clk);
        pulse_wake();
        dwell(2'b11, n); chk("R10 idle entry completes", n, L_II - 1);
        dwell(2'b01, n); chk("R10 one idle cycle", n, 1);
        dwell(2'b11, n); chk("R4 idle exit length", n, L_IO);
        busy = 1'b1;
        chk("R10 back in run", int'(state), 0);
        repeat (5) @(negedge clk);

        // wake latched during sleep entry: a wrong shutdown
        busy = 1'b0;
        wait_pdn();
        pulse_wake();
        dwell(2'b11, n); chk("R10 sleep entry completes", n, L_SI - 1);
        dwell(2'b10, n); chk("R10 one sleep cycle", n, 1);
        dwell(2'b11, n); chk("R10 wake follows", n, L_WK);
        chk("R11 shut count 3", int'(sh_cnt), 3);
        chk("R11 early wake is wrong", int'(wr_cnt), 1);

        // saturation
        wait_pdn(); pulse_wake(); wait_run();
        chk("R12 shut count saturated", int'(sh_cnt), 3);
        chk("R11 wrong count 2", int'(wr_cnt), 2);
        wait_pdn(); pulse_wake(); wait_run();
        wait_pdn(); pulse_wake(); wait_run();
        chk("R12 wrong count saturated", int'(wr_cnt), 3);
        chk("R12 shut count stays", int'(sh_cnt), 3);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule